// File: doc/BRIEF.md
# Power-Management Host Mailbox Channel

This block is a second byte-wide mailbox between a host and local firmware. The host reaches it through two I/O ports. Writing either port hands a byte to the firmware. Reading the data port collects the firmware's answer, and reading the command port returns a status byte. The command port always sits a fixed offset (4) above a data port base address, and that base is set from an input. Firmware sees the channel as a few byte registers on a local bus. It reads the incoming byte, posts a result byte and keeps a general-purpose "busy" flag, which the host can see while a request is being handled.

The channel keeps an input-full flag, an output-full flag and a flag that records which port delivered the last byte. From these it requests an input-full interrupt and an output-empty interrupt, each with its own enable. A routing bit chooses between two modes. In shared mode, those requests are merged onto the interrupt lines that another channel also uses. In dedicated mode, they drive their own lines.

Top module: `pm_mailbox_ch`

## Requirements
- R1: After reset, the status byte, data-in, data-out, interrupt enables and routing bit are all zero, and every interrupt output is low while the channel-1 request inputs are low.
- R2: A host write to the data port base stores the byte as data-in, sets input-full (status bit 1) and clears the command flag (status bit 3). A host write to base+4 does the same but sets the command flag.
- R3: A local read of offset 0x14 returns data-in and clears input-full on that clock edge. If a host write lands in the same cycle, input-full stays set.
- R4: A local write to offset 0x11 loads the result byte and sets output-full (status bit 0). A host read of the data port returns that byte and clears output-full. A local write in the same cycle wins, so output-full stays set.
- R5: A host read of base+4 returns the status byte {4'b0, command flag, busy flag, input-full, output-full} and changes no state. A local read of offset 0x10 returns the same byte.
- R6: A local write to offset 0x10 sets the busy flag (status bit 2) from data bit 2. The other data bits are ignored.
- R7: Offset 0x16 holds the input-full interrupt enable in bit 0 and the output-empty interrupt enable in bit 1. The input-full request is high while input-full and bit 0 are both set. The output-empty request is high while output-full is clear and bit 1 is set.
- R8: Bit 5 of offset 0x19 selects routing. When it is 0, the channel's requests are ORed into the shared lines together with the channel-1 request inputs, and the dedicated lines stay low. When it is 1, the channel's requests drive only the dedicated lines, and the shared lines carry only the channel-1 inputs.
- R9: Host accesses to addresses other than base and base+4 change no state and read 0. Local reads of unmapped offsets return 0.
- R10: Both port addresses follow the base input. Once the base moves, the old addresses are no longer decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataPortBase | input | 16 | Host data port address; command port is this plus 4 |
| hostValid | input | 1 | Host access strobe, one cycle per access |
| hostWrite | input | 1 | 1 = host write, 0 = host read |
| hostAddr | input | 16 | Host I/O address |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational on address) |
| locValid | input | 1 | Local register access strobe |
| locWrite | input | 1 | 1 = local write, 0 = local read |
| locAddr | input | 8 | Local register offset |
| locWdata | input | 8 | Local write byte |
| locRdata | output | 8 | Local read byte (combinational on offset) |
| ch1IbfReq | input | 1 | Channel-1 input-full request to merge in shared mode |
| ch1ObeReq | input | 1 | Channel-1 output-empty request to merge in shared mode |
| sharedIbfIrq | output | 1 | Combined input-full interrupt line |
| sharedObeIrq | output | 1 | Combined output-empty interrupt line |
| ch2IbfIrq | output | 1 | Dedicated input-full interrupt line |
| ch2ObeIrq | output | 1 | Dedicated output-empty interrupt line |

## Verification
If a full flag is wrong, the host sees it in the status byte on the very next access to base+4, and an enabled interrupt line goes to the wrong level in the same cycle. A stale data register shows up as the wrong byte on the next read by either side. The queue-based bench catches this on the first transfer after the fault. The same-cycle collisions on input-full and output-full are driven on purpose, because a wrong priority shows up one cycle later as a lost or phantom full flag. Routing faults show up as a request that appears on the wrong line pair in the same cycle the routing bit or a flag changes.

// File: rtl/pm_mbx_pkg.sv
package pm_mbx_pkg;

  // Local register offsets (decoded by firmware drivers, kept fixed)
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_DOUT   = 8'h11;
  localparam logic [7:0] OFS_DIN    = 8'h14;
  localparam logic [7:0] OFS_CTRL   = 8'h16;
  localparam logic [7:0] OFS_MBX    = 8'h19;

  // Status bit positions as seen by host and firmware
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_GPF = 2;
  localparam int ST_CMD = 3;

  localparam int CTL_IBFIE = 0;
  localparam int CTL_OBEIE = 1;
  localparam int MBX_DED   = 5;

  typedef struct packed {
    logic hostDataWr;
    logic hostCmdWr;
    logic hostDataRd;
    logic locStatusWr;
    logic locDoutWr;
    logic locDinRd;
    logic locCtrlWr;
    logic locMbxWr;
  } mbxStrobes_t;

  typedef enum logic [1:0] {HSEL_NONE, HSEL_DATA, HSEL_CMD} hostSel_t;

  typedef enum logic [2:0] {
    LSEL_NONE, LSEL_STATUS, LSEL_DOUT, LSEL_DIN, LSEL_CTRL, LSEL_MBX
  } locSel_t;

endpackage

// File: rtl/pm_mbx_ctrl.sv
module pm_mbx_ctrl
  import pm_mbx_pkg::*;
#(
  parameter int HOST_AW    = 16,
  parameter int LOC_AW     = 8,
  parameter int CMD_OFFSET = 4
) (
  input  logic [HOST_AW-1:0] dataPortBase,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               locValid,
  input  logic               locWrite,
  input  logic [LOC_AW-1:0]  locAddr,
  output mbxStrobes_t        strobes,
  output hostSel_t           hostSel,
  output locSel_t            locSel
);

  localparam logic [HOST_AW-1:0] CMD_DELTA = HOST_AW'(CMD_OFFSET);

  logic [HOST_AW-1:0] cmdPortAddr;
  logic               hitData;
  logic               hitCmd;
  logic [7:0]         locOfs;

  assign cmdPortAddr = dataPortBase + CMD_DELTA;
  assign hitData     = (hostAddr == dataPortBase);
  assign hitCmd      = (hostAddr == cmdPortAddr) && !hitData;
  assign locOfs      = 8'(locAddr);

  always_comb begin
    if (hitData)     hostSel = HSEL_DATA;
    else if (hitCmd) hostSel = HSEL_CMD;
    else             hostSel = HSEL_NONE;
  end

  always_comb begin
    unique case (locOfs)
      OFS_STATUS: locSel = LSEL_STATUS;
      OFS_DOUT:   locSel = LSEL_DOUT;
      OFS_DIN:    locSel = LSEL_DIN;
      OFS_CTRL:   locSel = LSEL_CTRL;
      OFS_MBX:    locSel = LSEL_MBX;
      default:    locSel = LSEL_NONE;
    endcase
  end

  always_comb begin
    strobes             = '0;
    strobes.hostDataWr  = hostValid &&  hostWrite && hitData;
    strobes.hostCmdWr   = hostValid &&  hostWrite && hitCmd;
    strobes.hostDataRd  = hostValid && !hostWrite && hitData;
    strobes.locStatusWr = locValid  &&  locWrite  && (locSel == LSEL_STATUS);
    strobes.locDoutWr   = locValid  &&  locWrite  && (locSel == LSEL_DOUT);
    strobes.locDinRd    = locValid  && !locWrite  && (locSel == LSEL_DIN);
    strobes.locCtrlWr   = locValid  &&  locWrite  && (locSel == LSEL_CTRL);
    strobes.locMbxWr    = locValid  &&  locWrite  && (locSel == LSEL_MBX);
  end

endmodule

// File: rtl/pm_mbx_dpath.sv
module pm_mbx_dpath
  import pm_mbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  mbxStrobes_t strobes,
  input  hostSel_t    hostSel,
  input  locSel_t     locSel,
  input  logic [DW-1:0] hostWdata,
  input  logic [DW-1:0] locWdata,
  output logic [DW-1:0] hostRdata,
  output logic [DW-1:0] locRdata,
  input  logic        ch1IbfReq,
  input  logic        ch1ObeReq,
  output logic        sharedIbfIrq,
  output logic        sharedObeIrq,
  output logic        ch2IbfIrq,
  output logic        ch2ObeIrq
);

  logic [DW-1:0] dataIn;
  logic [DW-1:0] dataOut;
  logic          ibf, obf, gpf, cmdFlag;
  logic          ibfIe, obeIe, dedicated;
  logic [DW-1:0] statusByte;
  logic [DW-1:0] ctrlByte;
  logic [DW-1:0] mbxByte;
  logic          hostWr;
  logic          ibfReq, obeReq;

  assign hostWr = strobes.hostDataWr || strobes.hostCmdWr;

  // Host-to-firmware path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataIn  <= '0;
      ibf     <= 1'b0;
      cmdFlag <= 1'b0;
    end else begin
      if (hostWr) begin
        dataIn  <= hostWdata;
        cmdFlag <= strobes.hostCmdWr;
        ibf     <= 1'b1;
      end else if (strobes.locDinRd) begin
        ibf     <= 1'b0;
      end
    end
  end

  // Firmware-to-host path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      obf     <= 1'b0;
    end else begin
      if (strobes.locDoutWr) begin
        dataOut <= locWdata;
        obf     <= 1'b1;
      end else if (strobes.hostDataRd) begin
        obf     <= 1'b0;
      end
    end
  end

  // Firmware-owned configuration and busy flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpf       <= 1'b0;
      ibfIe     <= 1'b0;
      obeIe     <= 1'b0;
      dedicated <= 1'b0;
    end else begin
      if (strobes.locStatusWr) gpf <= locWdata[ST_GPF];
      if (strobes.locCtrlWr) begin
        ibfIe <= locWdata[CTL_IBFIE];
        obeIe <= locWdata[CTL_OBEIE];
      end
      if (strobes.locMbxWr) dedicated <= locWdata[MBX_DED];
    end
  end

  always_comb begin
    statusByte         = '0;
    statusByte[ST_OBF] = obf;
    statusByte[ST_IBF] = ibf;
    statusByte[ST_GPF] = gpf;
    statusByte[ST_CMD] = cmdFlag;
    ctrlByte            = '0;
    ctrlByte[CTL_IBFIE] = ibfIe;
    ctrlByte[CTL_OBEIE] = obeIe;
    mbxByte          = '0;
    mbxByte[MBX_DED] = dedicated;
  end

  always_comb begin
    unique case (hostSel)
      HSEL_DATA: hostRdata = dataOut;
      HSEL_CMD:  hostRdata = statusByte;
      default:   hostRdata = '0;
    endcase
  end

  always_comb begin
    unique case (locSel)
      LSEL_STATUS: locRdata = statusByte;
      LSEL_DOUT:   locRdata = dataOut;
      LSEL_DIN:    locRdata = dataIn;
      LSEL_CTRL:   locRdata = ctrlByte;
      LSEL_MBX:    locRdata = mbxByte;
      default:     locRdata = '0;
    endcase
  end

  // Interrupt requests and routing
  assign ibfReq       = ibf && ibfIe;
  assign obeReq       = !obf && obeIe;
  assign sharedIbfIrq = ch1IbfReq || (ibfReq && !dedicated);
  assign sharedObeIrq = ch1ObeReq || (obeReq && !dedicated);
  assign ch2IbfIrq    = ibfReq && dedicated;
  assign ch2ObeIrq    = obeReq && dedicated;

  AST_HOST_WR_SETS_IBF: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> ibf);  // R2
  AST_CMD_FLAG_FOLLOWS_PORT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hostCmdWr |=> (cmdFlag && dataIn == $past(hostWdata)));  // R2
  AST_DIN_READ_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.locDinRd && !hostWr) |=> !ibf);  // R3
  AST_DOUT_WRITE_SETS_OBF: assert property (@(posedge clk) disable iff (!rstN)
    strobes.locDoutWr |=> obf);  // R4
  AST_HOST_READ_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hostDataRd && !strobes.locDoutWr) |=> !obf);  // R4
  AST_IBF_HELD_WITHOUT_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr || strobes.locDinRd) |=> $stable(ibf));  // R9
  AST_SHARED_IBF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (sharedIbfIrq && !ch1IbfReq) |-> ibf);  // R7
  AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ch2IbfIrq, sharedIbfIrq && !ch1IbfReq}));  // R8

endmodule

// File: rtl/pm_mailbox_ch.sv
module pm_mailbox_ch
  import pm_mbx_pkg::*;
#(
  parameter int HOST_AW    = 16,
  parameter int LOC_AW     = 8,
  parameter int DW         = 8,
  parameter int CMD_OFFSET = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] dataPortBase,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DW-1:0]      hostWdata,
  output logic [DW-1:0]      hostRdata,
  input  logic               locValid,
  input  logic               locWrite,
  input  logic [LOC_AW-1:0]  locAddr,
  input  logic [DW-1:0]      locWdata,
  output logic [DW-1:0]      locRdata,
  input  logic               ch1IbfReq,
  input  logic               ch1ObeReq,
  output logic               sharedIbfIrq,
  output logic               sharedObeIrq,
  output logic               ch2IbfIrq,
  output logic               ch2ObeIrq
);

  mbxStrobes_t strobes;
  hostSel_t    hostSel;
  locSel_t     locSel;

  pm_mbx_ctrl #(
    .HOST_AW(HOST_AW), .LOC_AW(LOC_AW), .CMD_OFFSET(CMD_OFFSET)
  ) u_ctrl (
    .dataPortBase(dataPortBase),
    .hostValid(hostValid),
    .hostWrite(hostWrite),
    .hostAddr(hostAddr),
    .locValid(locValid),
    .locWrite(locWrite),
    .locAddr(locAddr),
    .strobes(strobes),
    .hostSel(hostSel),
    .locSel(locSel)
  );

  pm_mbx_dpath #(.DW(DW)) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .hostSel(hostSel),
    .locSel(locSel),
    .hostWdata(hostWdata),
    .locWdata(locWdata),
    .hostRdata(hostRdata),
    .locRdata(locRdata),
    .ch1IbfReq(ch1IbfReq),
    .ch1ObeReq(ch1ObeReq),
    .sharedIbfIrq(sharedIbfIrq),
    .sharedObeIrq(sharedObeIrq),
    .ch2IbfIrq(ch2IbfIrq),
    .ch2ObeIrq(ch2ObeIrq)
  );

endmodule

// File: tb/sim_pm_mailbox_ch.sv
`timescale 1ns/1ps
module sim_pm_mailbox_ch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] hostBase = 16'h0200;
  logic        hostValid = 1'b0, hostWrite = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0, hostRdata;
  logic        locValid = 1'b0, locWrite = 1'b0;
  logic [7:0]  locAddr = '0, locWdata = '0, locRdata;
  logic        ch1IbfReq = 1'b0, ch1ObeReq = 1'b0;
  logic        sharedIbfIrq, sharedObeIrq, ch2IbfIrq, ch2ObeIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] fwQ[$];    // bytes the firmware should read from data-in
  logic [7:0] hostQ[$];  // bytes the host should read from the data port

  always #4 clk = ~clk;  // 125 MHz

  pm_mailbox_ch u0 (
    .clk(clk), .rstN(rstN), .dataPortBase(hostBase),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .locValid(locValid), .locWrite(locWrite), .locAddr(locAddr),
    .locWdata(locWdata), .locRdata(locRdata),
    .ch1IbfReq(ch1IbfReq), .ch1ObeReq(ch1ObeReq),
    .sharedIbfIrq(sharedIbfIrq), .sharedObeIrq(sharedObeIrq),
    .ch2IbfIrq(ch2IbfIrq), .ch2ObeIrq(ch2ObeIrq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostOp(bit wr, logic [15:0] a, logic [7:0] d, output logic [7:0] rd);
    @(posedge clk); #1;
    hostValid = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    if (wr && (a == hostBase || a == hostBase + 16'd4)) fwQ.push_back(d);
    #3 rd = hostRdata;
    @(posedge clk); #1;
    hostValid = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic locOp(bit wr, logic [7:0] a, logic [7:0] d, output logic [7:0] rd);
    @(posedge clk); #1;
    locValid = 1'b1; locWrite = wr; locAddr = a; locWdata = d;
    if (wr && a == 8'h11) hostQ.push_back(d);
    #3 rd = locRdata;
    @(posedge clk); #1;
    locValid = 1'b0; locWrite = 1'b0;
  endtask

  // Scoreboard monitor: compares transferred bytes at the falling edge
  initial forever begin
    @(negedge clk);
    if (rstN && locValid && !locWrite && locAddr == 8'h14) begin
      if (fwQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected data-in read actual=%h expected=none", locRdata);
      end else check("R3 data-in byte", locRdata, fwQ.pop_front());
    end
    if (rstN && hostValid && !hostWrite && hostAddr == hostBase) begin
      if (hostQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4 unexpected data-port read actual=%h expected=none", hostRdata);
      end else check("R4 data-port byte", hostRdata, hostQ.pop_front());
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, r2;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R1 status", r, 8'h00);
    locOp(0, 8'h16, 8'h00, r);             check("R1 ctrl", r, 8'h00);
    locOp(0, 8'h19, 8'h00, r);             check("R1 mbx", r, 8'h00);
    locOp(0, 8'h11, 8'h00, r);             check("R1 data-out", r, 8'h00);
    check("R1 irqs", {4'b0, sharedIbfIrq, sharedObeIrq, ch2IbfIrq, ch2ObeIrq}, 8'h00);

    // R2/R3: data port write then firmware read
    hostOp(1, hostBase, 8'hA5, r);
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R2 data write status", r, 8'h02);
    locOp(0, 8'h14, 8'h00, r);
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R3 ibf cleared", r, 8'h00);

    // R2/R5: command port write
    hostOp(1, hostBase + 16'd4, 8'h3C, r);
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R2 cmd write status", r, 8'h0A);
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R5 status read no side effect", r, 8'h0A);
    locOp(0, 8'h10, 8'h00, r);             check("R5 local status", r, 8'h0A);
    locOp(0, 8'h14, 8'h00, r);

    // R4: result byte to host
    locOp(1, 8'h11, 8'h5E, r);
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R4 obf set", r, 8'h09);
    hostOp(0, hostBase, 8'h00, r);
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R4 obf cleared", r, 8'h08);

    // R6: busy flag, other bits ignored
    locOp(1, 8'h10, 8'hFF, r);
    locOp(0, 8'h10, 8'h00, r);             check("R6 busy set only", r, 8'h0C);
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R6 busy seen by host", r, 8'h0C);
    locOp(1, 8'h10, 8'h00, r);
    locOp(0, 8'h10, 8'h00, r);             check("R6 busy cleared", r, 8'h08);

    // R7/R8: input-full interrupt, shared then dedicated
    locOp(1, 8'h16, 8'h01, r);
    check("R7 no ibf irq when empty", {6'b0, sharedIbfIrq, ch2IbfIrq}, 8'h00);
    hostOp(1, hostBase, 8'h11, r);
    check("R8 shared ibf routing", {6'b0, sharedIbfIrq, ch2IbfIrq}, 8'h02);
    locOp(1, 8'h19, 8'h20, r);
    check("R8 dedicated ibf routing", {6'b0, sharedIbfIrq, ch2IbfIrq}, 8'h01);
    ch1IbfReq = 1'b1; #1;
    check("R8 channel-1 on shared line", {6'b0, sharedIbfIrq, ch2IbfIrq}, 8'h03);
    ch1IbfReq = 1'b0;

    // R3: host write collides with firmware read of data-in
    fork
      hostOp(1, hostBase, 8'h22, r);
      locOp(0, 8'h14, 8'h00, r2);
    join
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R3 collision keeps ibf", r, 8'h02);
    check("R7 ibf irq still high", {6'b0, sharedIbfIrq, ch2IbfIrq}, 8'h01);
    locOp(0, 8'h14, 8'h00, r);
    check("R7 ibf irq drops", {6'b0, sharedIbfIrq, ch2IbfIrq}, 8'h00);

    // R7/R8: output-empty interrupt
    locOp(1, 8'h16, 8'h02, r);
    check("R7 obe irq while empty", {6'b0, sharedObeIrq, ch2ObeIrq}, 8'h01);
    locOp(1, 8'h11, 8'h66, r);
    check("R7 obe irq drops when full", {6'b0, sharedObeIrq, ch2ObeIrq}, 8'h00);

    // R4: firmware write collides with host data read
    fork
      hostOp(0, hostBase, 8'h00, r);
      locOp(1, 8'h11, 8'h77, r2);
    join
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R4 collision keeps obf", r, 8'h01);
    hostOp(0, hostBase, 8'h00, r);
    check("R7 obe irq returns", {6'b0, sharedObeIrq, ch2ObeIrq}, 8'h01);
    locOp(1, 8'h19, 8'h00, r);
    check("R8 shared obe routing", {6'b0, sharedObeIrq, ch2ObeIrq}, 8'h02);

    // R9: unmapped accesses
    locOp(1, 8'h11, 8'h44, r);
    hostOp(1, hostBase + 16'd1, 8'h99, r);
    hostOp(0, hostBase + 16'd2, 8'h00, r); check("R9 unmapped host read", r, 8'h00);
    hostOp(0, hostBase + 16'd4, 8'h00, r); check("R9 no state change", r, 8'h01);
    locOp(0, 8'h12, 8'h00, r);             check("R9 unmapped local read", r, 8'h00);
    hostOp(0, hostBase, 8'h00, r);

    // R10: moved base
    hostBase = 16'h0300;
    hostOp(1, 16'h0304, 8'h5A, r);
    hostOp(0, 16'h0304, 8'h00, r);         check("R10 new command port", r, 8'h0A);
    hostOp(0, 16'h0204, 8'h00, r);         check("R10 old port dead", r, 8'h00);
    locOp(0, 8'h14, 8'h00, r);

    repeat (2) @(posedge clk);
    check("R3 scoreboard drained", 8'(fwQ.size()), 8'h00);
    check("R4 scoreboard drained", 8'(hostQ.size()), 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule